// File: doc/BRIEF.md
# Arbitrary Transmit Pulse Sequencer

This block is the digital waveform engine of a T1 transmitter. Software loads one pulse shape into a sample table. The shape covers three bit periods at 14 sample slots per period. The block plays that shape out at a sub-bit phase rate, and each bit period takes 13 phase steps. For every mark on the bipolar input pair, the shape is emitted with a positive or a negative sign. The tails of the two previous marks are summed into every output sample. The result is a signed amplitude code for an external DAC.

Samples arrive on a serial load path. One bit is shifted in per valid cycle, least significant bit first. Each completed byte goes to the next table slot in sequence. Any stored slot can be read back on a separate read port. New samples reach playback only at a bit boundary, so every output sample within one bit period is computed from a single version of the table.

Top module: `tx_pulse_seq`

## Requirements
- R1: After a synchronous active-low reset, `dac_code` is 0 and every table slot reads back as 0.
- R2: After `load_start`, each group of 8 `load_bit_vld` cycles forms one signed 8-bit sample, with the first bit as bit 0. Samples are written to slots 0, 1, 2, … in turn, the slot number wrapping from 41 to 0. Slot k is phase (k mod 14) of bit period (k / 14), so slot = 14·interval + phase. `rd_sample` shows the stored value of slot `rd_slot`.
- R3: A phase counter advances on each `phase_en` and wraps after 13 steps. The 13th step of each bit period is the bit boundary, and the mark pair is sampled there. On step p (0..12), `dac_code` is loaded with the sum over intervals j = 0..2 of sign(j) · slot(14·j + p). Here sign(0) belongs to the mark sampled at the last boundary, sign(1) to the mark one boundary older, and sign(2) to the mark two boundaries older.
- R4: Slots 13, 27 and 41 (phase 14 of each interval) are stored and can be read back, but they never contribute to `dac_code`.
- R5: `mark_pos`=1 with `mark_neg`=0 gives sign +1, and `mark_neg`=1 with `mark_pos`=0 gives sign −1. Both low (a space) or both high give sign 0.
- R6: The contributions of the current mark and the two previous marks add together. A mark stops contributing once its third bit period ends.
- R7: The sum saturates to the signed 8-bit range: values above 127 give 127 and values below −128 give −128. A −128 sample under a negative mark counts as +128.
- R8: Table writes reach playback only at the next bit boundary. Every output within one bit period uses the table as it stood at that period's opening boundary.
- R9: `dac_code` changes only on the clock edge that samples `phase_en` high, and holds its value otherwise.
- R10: `load_start` returns the slot pointer to 0 and discards a partly shifted byte. It takes priority over a valid bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_start | input | 1 | Restart the serial loader at slot 0 |
| load_bit_vld | input | 1 | `load_bit` carries a sample bit this cycle |
| load_bit | input | 1 | Serial sample bit, LSB first |
| rd_slot | input | 6 | Table slot to read back |
| rd_sample | output | 8 | Stored value of `rd_slot` (0 when out of range) |
| phase_en | input | 1 | Phase-rate step enable |
| mark_pos | input | 1 | Positive mark request for the next bit |
| mark_neg | input | 1 | Negative mark request for the next bit |
| dac_code | output | 8 | Signed two's-complement amplitude code |

## Verification
The assertions assume the following about the inputs:
- `phase_en` is a single-cycle strobe.
- The mark pair is valid on the step that closes a bit period.
- The loader is driven only with `load_start` and `load_bit_vld`.

No assumption is made about how loads and phase steps interleave. The stimulus respects these assumptions:
- Every phase step is followed by an idle cycle.
- The mark pair is held for the whole bit period.
- Table loads happen between phase steps, including one reload in the middle of a bit period.

The expected codes therefore depend only on the order of steps, marks and loads, never on the spacing between them.

// File: rtl/tx_pulse_pkg.sv
// Shared types for the arbitrary transmit pulse sequencer.
// Assumes two's-complement samples and a two-bit code per stored mark.
package tx_pulse_pkg;

    // Sign code kept for each mark still contributing to the output.
    typedef enum logic [1:0] {
        MK_SPACE = 2'd0,
        MK_POS   = 2'd1,
        MK_NEG   = 2'd2
    } mark_e;

endpackage

// File: rtl/tps_loader.sv
// Serial sample loader.
// Shifts bits in LSB first and emits one table write per completed sample.
// The target slot advances 0..N_SLOT-1 and wraps.
// Assumes load_start is level-sampled; it overrides a valid bit in the same cycle.
module tps_loader #(
    parameter int SAMP_W = 8,
    parameter int N_SLOT = 42,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_start,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [SAMP_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(SAMP_W);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(SAMP_W - 1);
    localparam logic [ADDR_W-1:0] LAST_SLOT = ADDR_W'(N_SLOT - 1);

    logic [SAMP_W-2:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] ptr;

    // Write strobe for a completed sample; the newest bit is the MSB.
    always_comb begin
        wr_en   = bit_vld && !load_start && (bit_cnt == LAST_BIT);
        wr_addr = ptr;
        wr_data = {bit_in, shreg};
    end

    // Shift register, bit counter and slot pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || load_start) begin
            shreg   <= '0;
            bit_cnt <= '0;
            ptr     <= '0;
        end else if (bit_vld) begin
            shreg <= {bit_in, shreg[SAMP_W-2:1]};
            if (bit_cnt == LAST_BIT) begin
                bit_cnt <= '0;
                ptr     <= (ptr == LAST_SLOT) ? '0 : ptr + 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // A completed sample moves the pointer to the following slot.
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == (($past(ptr) == LAST_SLOT) ? '0 : $past(ptr) + 1'b1)));

    // A restart always returns the loader to slot 0.
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_start |=> (ptr == '0));

endmodule

// File: rtl/tps_table.sv
// Sample table with a host-side staging copy and a playback copy.
// The staging copy holds every slot, including phase 14 of each interval.
// The playback copy holds only the 13 played phases.
// It is refreshed from the staging copy when commit is high.
// Assumes the tap phase index stays below PH_PER_UI.
module tps_table #(
    parameter int SAMP_W      = 8,
    parameter int SLOT_PER_UI = 14,
    parameter int PH_PER_UI   = 13,
    parameter int N_UI        = 3,
    parameter int ADDR_W      = 6,
    parameter int PH_W        = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [SAMP_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [SAMP_W-1:0]            rd_data,
    input  logic                         commit,
    input  logic [PH_W-1:0]              tap_phase,
    output logic [N_UI-1:0][SAMP_W-1:0]  taps
);
    localparam int N_SLOT = SLOT_PER_UI * N_UI;

    logic [SAMP_W-1:0] stage_q [N_SLOT];
    logic [N_UI-1:0][PH_PER_UI-1:0][SAMP_W-1:0] play_q;

    // Host writes into the staging copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOT; i++) stage_q[i] <= '0;
        end else if (wr_en && (int'(wr_addr) < N_SLOT)) begin
            stage_q[wr_addr] <= wr_data;
        end
    end

    // Readback of the staging copy; out-of-range slots read as zero.
    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < N_SLOT) rd_data = stage_q[rd_addr];
    end

    // Playback copy: one register per played phase, loaded at a bit boundary.
    generate
        for (genvar j = 0; j < N_UI; j++) begin : g_ui
            for (genvar p = 0; p < PH_PER_UI; p++) begin : g_ph
                always_ff @(posedge clk) begin
                    if (!rst_n)      play_q[j][p] <= '0;
                    else if (commit) play_q[j][p] <= stage_q[j*SLOT_PER_UI + p];
                end
            end
            // Tap of interval j at the current phase.
            assign taps[j] = play_q[j][tap_phase];
        end
    endgenerate

    // Playback samples change only on a commit.
    p_play_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(play_q));

    // The tap phase never points at the unplayed slot.
    p_tap_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tap_phase) < PH_PER_UI);

endmodule

// File: rtl/tps_sequencer.sv
// Phase counter and mark history.
// Counts PH_PER_UI phase steps per bit.
// Flags the closing step as the bit boundary, where the mark pair is captured.
// Shifts the N_UI-deep sign history at that boundary.
// Assumes phase_en is a one-cycle strobe and N_UI >= 2.
module tps_sequencer #(
    parameter int PH_PER_UI = 13,
    parameter int N_UI      = 3,
    parameter int PH_W      = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   phase_en,
    input  logic                   mark_pos,
    input  logic                   mark_neg,
    output logic [PH_W-1:0]        phase,
    output logic                   boundary,
    output logic [N_UI-1:0][1:0]   hist
);
    import tx_pulse_pkg::*;

    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PH_PER_UI - 1);

    mark_e new_mark;

    // Boundary strobe on the last phase step of the bit.
    assign boundary = phase_en && (phase == LAST_PH);

    // Encode the mark pair; both or neither asserted means no pulse.
    always_comb begin
        case ({mark_neg, mark_pos})
            2'b01:   new_mark = MK_POS;
            2'b10:   new_mark = MK_NEG;
            default: new_mark = MK_SPACE;
        endcase
    end

    // Phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        phase <= '0;
        else if (boundary) phase <= '0;
        else if (phase_en) phase <= phase + 1'b1;
    end

    // Sign history: slot 0 is the current bit, higher slots are older.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (boundary) begin
            hist[0] <= new_mark;
            for (int j = 1; j < N_UI; j++) hist[j] <= hist[j-1];
        end
    end

    // The phase counter stays inside one bit period.
    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase) < PH_PER_UI);

    // A positive-only mark at the boundary becomes the current sign.
    p_mark_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && mark_pos && !mark_neg) |=> (hist[0] == MK_POS));

    // Both marks high at the boundary is stored as a space.
    p_mark_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && mark_pos && mark_neg) |=> (hist[0] == MK_SPACE));

    generate
        for (genvar j = 1; j < N_UI; j++) begin : g_chk
            // Each older sign moves one slot deeper per boundary.
            p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
                boundary |=> (hist[j] == $past(hist[j-1])));
        end
    endgenerate

endmodule

// File: rtl/tps_mixer.sv
// Signed mixer.
// Applies each mark's sign to the matching tap, sums the N_UI terms,
// saturates to SAMP_W bits and registers the result on phase_en.
// Assumes taps and hist are stable during the cycle phase_en is high.
module tps_mixer #(
    parameter int SAMP_W = 8,
    parameter int N_UI   = 3,
    parameter int SUM_W  = 11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         phase_en,
    input  logic [N_UI-1:0][1:0]         hist,
    input  logic [N_UI-1:0][SAMP_W-1:0]  taps,
    output logic [SAMP_W-1:0]            dac_code
);
    import tx_pulse_pkg::*;

    localparam int MAX_I = (1 << (SAMP_W - 1)) - 1;
    localparam int MIN_I = -(1 << (SAMP_W - 1));

    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] term;
    logic [SAMP_W-1:0]       sat_code;

    // Signed sum of all still-active contributions.
    always_comb begin
        acc = '0;
        for (int j = 0; j < N_UI; j++) begin
            term = $signed({{(SUM_W-SAMP_W){taps[j][SAMP_W-1]}}, taps[j]});
            case (hist[j])
                MK_POS:  acc = acc + term;
                MK_NEG:  acc = acc - term;
                default: acc = acc;
            endcase
        end
    end

    // Clamp to the signed output range.
    always_comb begin
        if (int'(acc) > MAX_I)      sat_code = SAMP_W'(MAX_I);
        else if (int'(acc) < MIN_I) sat_code = SAMP_W'(MIN_I);
        else                        sat_code = acc[SAMP_W-1:0];
    end

    // Output register, loaded once per phase step.
    always_ff @(posedge clk) begin
        if (!rst_n)        dac_code <= '0;
        else if (phase_en) dac_code <= sat_code;
    end

    // Output holds between phase steps.
    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_en |=> $stable(dac_code));

    // With no live marks the output is silent.
    p_space_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en && (hist == '0)) |=> (dac_code == '0));

endmodule

// File: rtl/tx_pulse_seq.sv
// Arbitrary transmit pulse sequencer, top level.
// Connects the serial loader, the double-copy sample table, the phase/mark
// sequencer and the saturating mixer.
// Assumes phase_en is a one-cycle strobe at the sub-bit phase rate.
module tx_pulse_seq #(
    parameter int SAMP_W      = 8,
    parameter int SLOT_PER_UI = 14,
    parameter int PH_PER_UI   = 13,
    parameter int N_UI        = 3,
    parameter int ADDR_W      = $clog2(SLOT_PER_UI * N_UI)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_start,
    input  logic              load_bit_vld,
    input  logic              load_bit,
    input  logic [ADDR_W-1:0] rd_slot,
    output logic [SAMP_W-1:0] rd_sample,
    input  logic              phase_en,
    input  logic              mark_pos,
    input  logic              mark_neg,
    output logic [SAMP_W-1:0] dac_code
);
    localparam int N_SLOT = SLOT_PER_UI * N_UI;
    localparam int PH_W   = $clog2(PH_PER_UI);
    localparam int SUM_W  = SAMP_W + $clog2(N_UI) + 1;

    logic                         wr_en;
    logic [ADDR_W-1:0]            wr_addr;
    logic [SAMP_W-1:0]            wr_data;
    logic [PH_W-1:0]              phase;
    logic                         boundary;
    logic [N_UI-1:0][1:0]         hist;
    logic [N_UI-1:0][SAMP_W-1:0]  taps;

    tps_loader #(
        .SAMP_W (SAMP_W),
        .N_SLOT (N_SLOT),
        .ADDR_W (ADDR_W)
    ) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_start (load_start),
        .bit_vld    (load_bit_vld),
        .bit_in     (load_bit),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    tps_table #(
        .SAMP_W      (SAMP_W),
        .SLOT_PER_UI (SLOT_PER_UI),
        .PH_PER_UI   (PH_PER_UI),
        .N_UI        (N_UI),
        .ADDR_W      (ADDR_W),
        .PH_W        (PH_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_slot),
        .rd_data   (rd_sample),
        .commit    (boundary),
        .tap_phase (phase),
        .taps      (taps)
    );

    tps_sequencer #(
        .PH_PER_UI (PH_PER_UI),
        .N_UI      (N_UI),
        .PH_W      (PH_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_en (phase_en),
        .mark_pos (mark_pos),
        .mark_neg (mark_neg),
        .phase    (phase),
        .boundary (boundary),
        .hist     (hist)
    );

    tps_mixer #(
        .SAMP_W (SAMP_W),
        .N_UI   (N_UI),
        .SUM_W  (SUM_W)
    ) u_mix (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_en (phase_en),
        .hist     (hist),
        .taps     (taps),
        .dac_code (dac_code)
    );

endmodule

// File: tb/tx_pulse_seq_test.sv
`timescale 1ns/1ps
module tx_pulse_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_start = 1'b0;
    logic       load_bit_vld = 1'b0;
    logic       load_bit = 1'b0;
    logic [5:0] rd_slot = '0;
    logic [7:0] rd_sample;
    logic       phase_en = 1'b0;
    logic       mark_pos = 1'b0;
    logic       mark_neg = 1'b0;
    logic [7:0] dac_code;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench model state.
    int stg [42];
    int act [42];
    int pat [42];
    int mptr = 0;
    int h0 = 0, h1 = 0, h2 = 0;

    always #2.5 clk = ~clk;

    tx_pulse_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_start   (load_start),
        .load_bit_vld (load_bit_vld),
        .load_bit     (load_bit),
        .rd_slot      (rd_slot),
        .rd_sample    (rd_sample),
        .phase_en     (phase_en),
        .mark_pos     (mark_pos),
        .mark_neg     (mark_neg),
        .dac_code     (dac_code)
    );

    function automatic int sat8(int v);
        if (v > 127)  return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic chk(string req, string what, int actual, int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); load_start = 1'b1;
        @(negedge clk); load_start = 1'b0;
        mptr = 0;
    endtask

    task automatic shift_byte(int v);
        for (int b = 0; b < 8; b++) begin
            @(negedge clk); load_bit_vld = 1'b1; load_bit = v[b];
        end
        @(negedge clk); load_bit_vld = 1'b0;
        stg[mptr] = v;
        mptr = (mptr == 41) ? 0 : mptr + 1;
    endtask

    task automatic load_pat();
        pulse_start();
        for (int i = 0; i < 42; i++) shift_byte(pat[i]);
    endtask

    function automatic int rd_val();
        return int'($signed(rd_sample));
    endfunction

    // One bit period: 13 phase steps, each checked; optional reload mid-period.
    task automatic step(int pos, int neg, bit reload, string req);
        int expv;
        for (int p = 0; p < 13; p++) begin
            @(negedge clk); phase_en = 1'b1; mark_pos = pos[0]; mark_neg = neg[0];
            @(negedge clk); phase_en = 1'b0;
            expv = sat8(h0 * act[p] + h1 * act[14 + p] + h2 * act[28 + p]);
            chk(req, $sformatf("phase %0d code", p), int'($signed(dac_code)), expv);
            @(negedge clk);
            chk("R9", "hold between steps", int'($signed(dac_code)), expv);
            if (p == 12) begin
                h2 = h1; h1 = h0;
                h0 = (pos != 0 && neg == 0) ? 1 : ((neg != 0 && pos == 0) ? -1 : 0);
                for (int i = 0; i < 42; i++) act[i] = stg[i];
            end
            if (reload && p == 5) load_pat();
        end
    endtask

    task automatic flush(string req);
        for (int k = 0; k < 3; k++) step(0, 0, 1'b0, req);
    endtask

    task automatic set_pat_a();
        for (int i = 0; i < 42; i++) pat[i] = ((i * 29 + 7) % 200) - 100;
        pat[13] = 111; pat[27] = 111; pat[41] = 111;
    endtask

    // R1: reset state.
    task automatic t_reset();
        chk("R1", "dac after reset", int'($signed(dac_code)), 0);
        foreach (rd_slot_list[k]) begin
            rd_slot = 6'(rd_slot_list[k]); #1;
            chk("R1", "slot after reset", rd_val(), 0);
        end
    endtask
    int rd_slot_list [4] = '{0, 13, 27, 41};

    // R2 / R4: serial load and readback of every slot, including phase 14.
    task automatic t_load();
        set_pat_a();
        load_pat();
        for (int i = 0; i < 42; i++) begin
            @(negedge clk); rd_slot = 6'(i); #1;
            chk((i % 14 == 13) ? "R4" : "R2", $sformatf("readback slot %0d", i), rd_val(), stg[i]);
        end
    endtask

    // R10: restart drops a partial byte and rewinds to slot 0.
    task automatic t_restart();
        pulse_start();
        for (int b = 0; b < 3; b++) begin
            @(negedge clk); load_bit_vld = 1'b1; load_bit = 1'b1;
        end
        @(negedge clk); load_bit_vld = 1'b1; load_bit = 1'b1; load_start = 1'b1;
        @(negedge clk); load_bit_vld = 1'b0; load_start = 1'b0;
        mptr = 0;
        shift_byte(90);
        rd_slot = 6'd0; #1;
        chk("R10", "slot 0 after restart", rd_val(), 90);
        rd_slot = 6'd1; #1;
        chk("R10", "slot 1 untouched", rd_val(), stg[1]);
        shift_byte(-77);
        rd_slot = 6'd1; #1;
        chk("R10", "slot 1 next in order", rd_val(), -77);
    endtask

    // R3 / R6: one positive pulse played across three intervals, then silence.
    task automatic t_single();
        set_pat_a(); load_pat();
        step(0, 0, 1'b0, "R3");
        step(1, 0, 1'b0, "R3");
        step(0, 0, 1'b0, "R3");
        step(0, 0, 1'b0, "R6");
        step(0, 0, 1'b0, "R6");
        step(0, 0, 1'b0, "R6");
    endtask

    // R5: negative pulse and an illegal both-high pair.
    task automatic t_polarity();
        step(0, 1, 1'b0, "R5");
        flush("R5");
        step(1, 1, 1'b0, "R5");
        flush("R5");
    endtask

    // R4: only the phase-14 slots are non-zero, so nothing may play.
    task automatic t_ignored();
        for (int i = 0; i < 42; i++) pat[i] = (i % 14 == 13) ? 127 : 0;
        load_pat();
        step(0, 0, 1'b0, "R4");
        step(1, 0, 1'b0, "R4");
        step(0, 1, 1'b0, "R4");
        step(1, 0, 1'b0, "R4");
        flush("R4");
    endtask

    // R6: overlapping pulses of mixed sign.
    task automatic t_overlap();
        set_pat_a(); load_pat();
        step(0, 0, 1'b0, "R6");
        step(1, 0, 1'b0, "R6");
        step(0, 1, 1'b0, "R6");
        step(1, 0, 1'b0, "R6");
        step(1, 0, 1'b0, "R6");
        flush("R6");
    endtask

    // R7: sums beyond both range limits, plus a negated -128.
    task automatic t_sat();
        for (int i = 0; i < 42; i++) pat[i] = 100;
        load_pat();
        step(0, 0, 1'b0, "R7");
        for (int k = 0; k < 3; k++) step(1, 0, 1'b0, "R7");
        for (int k = 0; k < 3; k++) step(0, 1, 1'b0, "R7");
        flush("R7");
        for (int i = 0; i < 42; i++) pat[i] = -128;
        load_pat();
        step(0, 0, 1'b0, "R7");
        step(0, 1, 1'b0, "R7");
        flush("R7");
    endtask

    // R8: a reload in mid-period is not seen until the next boundary.
    task automatic t_update();
        set_pat_a(); load_pat();
        step(0, 0, 1'b0, "R8");
        step(1, 0, 1'b0, "R8");
        for (int i = 0; i < 42; i++) pat[i] = 40 - i;
        step(1, 0, 1'b1, "R8");
        step(0, 1, 1'b0, "R8");
        flush("R8");
    endtask

    initial begin
        for (int i = 0; i < 42; i++) begin stg[i] = 0; act[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_restart();
        t_single();
        t_polarity();
        t_ignored();
        t_overlap();
        t_sat();
        t_update();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule